// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for an 8-bit successive-approximation converter. A single active-low blank/convert line controls everything. Driving it low starts a conversion. The controller then presents trial codes to an external DAC, one bit at a time from the most significant bit downward, and samples a comparator that reports whether the DAC value lies above the analog input. When the last bit has been decided, the data-ready output falls. A bounded number of cycles later, the result bus enables turn on.

Raising the line blanks the outputs. After a set delay, data-ready returns high and every result enable drops. A high level that arrives while a conversion is running halts that conversion and leaves data-ready and the bus untouched. Only a high level of at least a minimum width clears the converter, so that the next low level begins a fresh conversion. A short high pulse cannot start a conversion again.

All delays are clock-cycle parameters. The comparator is sampled once per bit period. In bipolar use the same codes are read as offset binary, which needs no change in the controller.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset, with the line held high, `ready_n` is 1, `result_oe` is 0, `result_q` is 0 and `trial_code` is 0, and no conversion starts however long the line stays high.
- R2: When the line is driven low in the armed state, `trial_code` shows only its most significant bit set (0x80) two clock edges later. `ready_n` stays 1 and `result_oe` stays 0 for the whole conversion.
- R3: Bits are decided from bit 7 down to bit 0, one per `BIT_CYCLES` cycles. A trial bit is kept when `cmp_above` is 0 (the DAC value does not exceed the input) and cleared when it is 1. For an input level v on the 0..255 scale, the final code therefore equals v.
- R4: `ready_n` falls exactly 2 + 8*`BIT_CYCLES` clock edges after the line is driven low.
- R5: `result_q` holds the final code when `ready_n` falls. All bits of `result_oe` turn on together exactly `OE_DELAY` cycles later, and never while `ready_n` is 1.
- R6: After a completed conversion, a high level lasting `BLANK_DELAY` or more cycles raises `ready_n` and clears `result_oe` `BLANK_DELAY`+1 edges after the line rises. A shorter high pulse leaves both outputs as they were.
- R7: A high level during a conversion halts it. `trial_code` freezes, `ready_n` stays 1 and `result_oe` stays 0. If the line returns low before `CLEAR_WIDTH` cycles have passed, the conversion neither resumes nor completes.
- R8: A high level of at least `CLEAR_WIDTH` cycles clears the converter, and the next low level starts a fresh conversion from 0x80. A high level of `CLEAR_WIDTH`-1 cycles does not clear it, and a following low level starts nothing.
- R9: `result_q` keeps the last completed code through blanking, halted conversions and idle time, until a later conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_conv_n | input | 1 | Blank/convert line: low converts, high blanks, a long high clears |
| cmp_above | input | 1 | Comparator: 1 when the DAC value exceeds the input |
| trial_code | output | 8 | Trial code driven to the DAC |
| result_q | output | 8 | Result register value for the bus |
| result_oe | output | 8 | Per-bit output enable for the result bus (1 = driven) |
| ready_n | output | 1 | Data ready, active low |

## Verification
The hardest states to reach are a halted conversion and a blanked-but-not-cleared converter. Both depend on the exact width of a high pulse relative to `BLANK_DELAY` and `CLEAR_WIDTH`, and on where that pulse falls inside the bit sequence. The stimulus produces them by placing high pulses at chosen cycle offsets after the line falls, including random offsets across every bit period. Pulse widths sit on both sides of each threshold, such as `CLEAR_WIDTH`-1 against `CLEAR_WIDTH` and `BLANK_DELAY`-1 against `BLANK_DELAY`. After each such pulse the bench watches for a long stretch that nothing restarts, and that the held result survives.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_CONV  = 2'd1,
    ST_DONE  = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sar_line_monitor.sv
module sar_line_monitor #(
  parameter int CLEAR_WIDTH = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               line_n_in,
  output logic                               line_hi,
  output logic [$clog2(CLEAR_WIDTH+1)-1:0]   high_run
);

  localparam int CW = $clog2(CLEAR_WIDTH + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(CLEAR_WIDTH);

  // Registered copy of the line and a saturating count of consecutive high samples
  always_ff @(posedge clk) begin
    if (rst) begin
      line_hi  <= 1'b1;
      high_run <= '0;
    end else begin
      line_hi <= line_n_in;
      if (!line_n_in) begin
        high_run <= '0;
      end else if (high_run != RUN_MAX) begin
        high_run <= high_run + CW'(1);
      end
    end
  end

  // R8: a low sample always breaks the high run
  a_r8_run_breaks: assert property (@(posedge clk) disable iff (rst)
    !line_n_in |=> (high_run == '0));

endmodule

// File: rtl/sar_approx_core.sv
module sar_approx_core #(
  parameter int WIDTH      = 8,
  parameter int BIT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             halt,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy,
  output logic             last_step,
  output logic [WIDTH-1:0] final_code
);

  localparam int PW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PW-1:0]    PH_LAST  = PW'(BIT_CYCLES - 1);
  localparam logic [IW-1:0]    IDX_TOP  = IW'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [PW-1:0]    phase;
  logic [IW-1:0]    idx;
  logic             step;
  logic [WIDTH-1:0] next_code;

  assign step      = busy && !halt && (phase == PH_LAST);
  assign last_step = step && (idx == '0);

  // Decision on the bit under test, then raise the next lower trial bit
  always_comb begin
    final_code = trial_code;
    if (cmp_above) final_code[idx] = 1'b0;
    next_code = final_code;
    if (idx != '0) next_code[idx - IW'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial_code <= '0;
      idx        <= '0;
      phase      <= '0;
      busy       <= 1'b0;
    end else if (start) begin
      trial_code <= MSB_ONLY;
      idx        <= IDX_TOP;
      phase      <= '0;
      busy       <= 1'b1;
    end else if (busy) begin
      if (halt) begin
        busy <= 1'b0;
      end else if (step) begin
        phase      <= '0;
        trial_code <= next_code;
        if (idx == '0) busy <= 1'b0;
        else           idx  <= idx - IW'(1);
      end else begin
        phase <= phase + PW'(1);
      end
    end
  end

  // R3: trial code only moves at a decision point or a fresh start
  a_r3_code_moves_on_step: assert property (@(posedge clk) disable iff (rst)
    (!start && !step) |=> $stable(trial_code));

  // R3: bits below the one under test stay clear during a conversion
  a_r3_lower_bits_clear: assert property (@(posedge clk) disable iff (rst)
    busy |-> ((trial_code & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0));

  // R2: a start presents the most significant bit alone
  a_r2_start_msb: assert property (@(posedge clk) disable iff (rst)
    start |=> (trial_code == MSB_ONLY) && busy);

endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage #(
  parameter int WIDTH    = 8,
  parameter int OE_DELAY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             finish,
  input  logic [WIDTH-1:0] final_code,
  input  logic             blank,
  output logic             ready_n,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] data_oe
);

  localparam int DW = (OE_DELAY > 1) ? $clog2(OE_DELAY) : 1;
  localparam logic [DW-1:0] D_LAST = DW'(OE_DELAY - 1);

  logic          pending;
  logic          oe_on;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_n <= 1'b1;
      oe_on   <= 1'b0;
      pending <= 1'b0;
      dcnt    <= '0;
      data_q  <= '0;
    end else if (finish) begin
      data_q  <= final_code;
      ready_n <= 1'b0;
      oe_on   <= 1'b0;
      pending <= 1'b1;
      dcnt    <= '0;
    end else if (blank) begin
      ready_n <= 1'b1;
      oe_on   <= 1'b0;
      pending <= 1'b0;
      dcnt    <= '0;
    end else if (pending) begin
      if (dcnt == D_LAST) begin
        oe_on   <= 1'b1;
        pending <= 1'b0;
      end else begin
        dcnt <= dcnt + DW'(1);
      end
    end
  end

  assign data_oe = {WIDTH{oe_on}};

  // R5: the bus is never driven while data-ready is inactive
  a_r5_oe_needs_ready: assert property (@(posedge clk) disable iff (rst)
    oe_on |-> !ready_n);

  // R5: enables follow data-ready, never on the same edge
  a_r5_oe_lags_ready: assert property (@(posedge clk) disable iff (rst)
    finish |=> !oe_on && !ready_n);

endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int BIT_CYCLES  = 4,
  parameter int OE_DELAY    = 3,
  parameter int BLANK_DELAY = 5,
  parameter int CLEAR_WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blank_conv_n,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] result_q,
  output logic [WIDTH-1:0] result_oe,
  output logic             ready_n
);

  localparam int CW = $clog2(CLEAR_WIDTH + 1);
  localparam logic [CW-1:0] RUN_CLEAR = CW'(CLEAR_WIDTH);
  localparam logic [CW-1:0] RUN_BLANK = CW'(BLANK_DELAY);

  initial begin
    assert (BLANK_DELAY >= 1 && BLANK_DELAY < CLEAR_WIDTH && OE_DELAY >= 1 &&
            BIT_CYCLES >= 1 && WIDTH >= 2)
      else $error("sar_conv_sequencer: inconsistent parameters");
  end

  seq_state_e       state;
  logic             line_hi;
  logic [CW-1:0]    high_run;
  logic             start;
  logic             halt;
  logic             blank;
  logic             core_busy;
  logic             last_step;
  logic [WIDTH-1:0] final_code;

  sar_line_monitor #(.CLEAR_WIDTH(CLEAR_WIDTH)) line_i (
    .clk       (clk),
    .rst       (rst),
    .line_n_in (blank_conv_n),
    .line_hi   (line_hi),
    .high_run  (high_run)
  );

  assign start = (state == ST_ARMED) && !line_hi;
  assign halt  = (state == ST_CONV) && line_hi;
  assign blank = (state == ST_DONE) && line_hi && (high_run == RUN_BLANK);

  sar_approx_core #(.WIDTH(WIDTH), .BIT_CYCLES(BIT_CYCLES)) core_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .halt       (halt),
    .cmp_above  (cmp_above),
    .trial_code (trial_code),
    .busy       (core_busy),
    .last_step  (last_step),
    .final_code (final_code)
  );

  sar_out_stage #(.WIDTH(WIDTH), .OE_DELAY(OE_DELAY)) out_i (
    .clk        (clk),
    .rst        (rst),
    .finish     (last_step),
    .final_code (final_code),
    .blank      (blank),
    .ready_n    (ready_n),
    .data_q     (result_q),
    .data_oe    (result_oe)
  );

  // Sequencing: armed -> converting -> done; halts and blanking park in WAIT until a long high
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_ARMED;
    end else begin
      unique case (state)
        ST_ARMED: if (!line_hi) state <= ST_CONV;
        ST_CONV: begin
          if (line_hi)        state <= ST_WAIT;
          else if (last_step) state <= ST_DONE;
        end
        ST_DONE:  if (blank) state <= ST_WAIT;
        ST_WAIT:  if (high_run == RUN_CLEAR) state <= ST_ARMED;
        default:  state <= ST_ARMED;
      endcase
    end
  end

  // R2: data-ready and bus stay inactive throughout a conversion
  a_r2_quiet_in_conv: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV) |-> ready_n && (result_oe == '0));

  // R7: a high line mid-conversion freezes the code and the outputs
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && line_hi) |=> (state == ST_WAIT) && $stable(trial_code) &&
                                      $stable(result_q) && ready_n);

  // R9: the result register only changes when a conversion completes
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    (state != ST_CONV) |=> $stable(result_q));

  // R6: a long enough high run after completion blanks the outputs
  a_r6_blank_effect: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && line_hi && high_run == RUN_BLANK) |=> ready_n && (result_oe == '0));

  // R8: a conversion can only begin from the armed (cleared) state
  a_r8_start_from_armed: assert property (@(posedge clk) disable iff (rst)
    $rose(core_busy) |-> ($past(state) == ST_ARMED));

  // R4: data-ready falls only at the end of a conversion
  a_r4_ready_from_conv: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_n) |-> ($past(state) == ST_CONV));

endmodule

// File: tb/sar_conv_sequencer_tb_top.sv
module sar_conv_sequencer_tb_top;

  localparam int W   = 8;
  localparam int BC  = 4;
  localparam int OED = 3;
  localparam int BLK = 5;
  localparam int CLR = 8;
  localparam int CONV_EDGES = 2 + 8 * BC;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         blank_conv_n = 1'b1;
  logic         cmp_above;
  logic [W-1:0] trial_code;
  logic [W-1:0] result_q;
  logic [W-1:0] result_oe;
  logic         ready_n;
  logic [W-1:0] vin = '0;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] last_res = '0;

  always #10 clk = ~clk;

  // Behavioural comparator: 1 when the DAC code is above the input level
  assign cmp_above = (trial_code > vin);

  sar_conv_sequencer #(
    .WIDTH(W), .BIT_CYCLES(BC), .OE_DELAY(OED), .BLANK_DELAY(BLK), .CLEAR_WIDTH(CLR)
  ) dut_i (
    .clk(clk), .rst(rst), .blank_conv_n(blank_conv_n), .cmp_above(cmp_above),
    .trial_code(trial_code), .result_q(result_q), .result_oe(result_oe), .ready_n(ready_n)
  );

  function automatic logic [W-1:0] model_sar(input logic [W-1:0] level);
    logic [W-1:0] c = '0;
    for (int b = W - 1; b >= 0; b--) begin
      c[b] = 1'b1;
      if (c > level) c[b] = 1'b0;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Called right after a negedge: drives the line low there and follows the conversion
  task automatic run_conv(input logic [W-1:0] v);
    int n = 0;
    vin = v;
    blank_conv_n = 1'b0;
    while (n < CONV_EDGES + 20) begin
      @(negedge clk);
      n++;
      if (n == 2) begin
        chk("R2 first trial code", 32'(trial_code), 32'h80);
        chk("R2 ready_n during conversion", 32'(ready_n), 32'd1);
        chk("R2 oe during conversion", 32'(result_oe), 32'd0);
      end
      if (!ready_n) break;
    end
    chk("R4 edges to ready_n fall", 32'(n), 32'(CONV_EDGES));
    chk("R3 result code", 32'(result_q), 32'(model_sar(v)));
    chk("R5 oe off at ready fall", 32'(result_oe), 32'd0);
    repeat (OED - 1) @(negedge clk);
    chk("R5 oe still off before delay", 32'(result_oe), 32'd0);
    @(negedge clk);
    chk("R5 oe on after delay", 32'(result_oe), 32'hFF);
    last_res = model_sar(v);
  endtask

  // Called right after a negedge: holds the line high for m samples
  task automatic high_run(input int m, input bit done_on);
    blank_conv_n = 1'b1;
    for (int k = 1; k <= m; k++) begin
      @(negedge clk);
      if (done_on && k == BLK) begin
        chk("R6 ready_n before blank delay", 32'(ready_n), 32'd0);
        chk("R6 oe before blank delay", 32'(result_oe), 32'hFF);
      end
      if (done_on && k == BLK + 1) begin
        chk("R6 ready_n after blank delay", 32'(ready_n), 32'd1);
        chk("R6 oe after blank delay", 32'(result_oe), 32'd0);
        chk("R9 result kept while blanked", 32'(result_q), 32'(last_res));
      end
    end
  endtask

  task automatic abort_at(input int a, input logic [W-1:0] v);
    logic [W-1:0] frozen;
    vin = v;
    blank_conv_n = 1'b0;
    repeat (a) @(negedge clk);
    blank_conv_n = 1'b1;
    repeat (2) @(negedge clk);
    frozen = trial_code;
    @(negedge clk);
    blank_conv_n = 1'b0;
    repeat (8 * BC + 6) @(negedge clk);
    chk("R7 trial frozen after halt", 32'(trial_code), 32'(frozen));
    chk("R7 ready_n stays high after halt", 32'(ready_n), 32'd1);
    chk("R7 oe stays off after halt", 32'(result_oe), 32'd0);
    chk("R9 result kept through halt", 32'(result_q), 32'(last_res));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int mode;
    int p;
    logic [W-1:0] t;
    logic [W-1:0] dir_vals [6] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE};
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    chk("R1 ready_n after reset", 32'(ready_n), 32'd1);
    chk("R1 oe after reset", 32'(result_oe), 32'd0);
    chk("R1 result after reset", 32'(result_q), 32'd0);
    chk("R1 no conversion while high", 32'(trial_code), 32'd0);

    // Directed codes, first from the armed state, then via long pulses
    run_conv(dir_vals[0]);
    for (int i = 1; i < 6; i++) begin
      high_run(CLR, 1'b1);
      run_conv(dir_vals[i]);
    end

    // Short pulse after completion: nothing changes
    high_run(BLK - 1, 1'b1);
    blank_conv_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 short pulse keeps ready_n", 32'(ready_n), 32'd0);
    chk("R6 short pulse keeps oe", 32'(result_oe), 32'hFF);
    chk("R9 short pulse keeps result", 32'(result_q), 32'(last_res));

    // Pulse one short of the clear width: blanks but does not clear
    high_run(CLR - 1, 1'b1);
    blank_conv_n = 1'b0;
    t = trial_code;
    repeat (CONV_EDGES + 10) @(negedge clk);
    chk("R8 no restart after short clear", 32'(ready_n), 32'd1);
    chk("R8 trial idle after short clear", 32'(trial_code), 32'(t));
    chk("R9 result kept after short clear", 32'(result_q), 32'(last_res));

    // Exactly the clear width restarts
    high_run(CLR, 1'b0);
    run_conv(8'h3C);

    // Directed halt in the middle of bit 4
    high_run(CLR, 1'b1);
    abort_at(2 + 3 * BC + 1, 8'hA5);
    high_run(CLR, 1'b0);
    run_conv(8'h5A);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      mode = $urandom_range(0, 2);
      if (mode == 0) begin
        high_run(CLR + $urandom_range(0, 3), 1'b1);
        run_conv(W'($urandom));
      end else if (mode == 1) begin
        high_run(CLR, 1'b1);
        abort_at($urandom_range(1, 8 * BC), W'($urandom));
        high_run(CLR + $urandom_range(0, 2), 1'b0);
        run_conv(W'($urandom));
      end else begin
        p = $urandom_range(1, BLK - 1);
        high_run(p, 1'b1);
        blank_conv_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 random short pulse ready_n", 32'(ready_n), 32'd0);
        chk("R6 random short pulse oe", 32'(result_oe), 32'hFF);
        chk("R9 random short pulse result", 32'(result_q), 32'(last_res));
      end
    end

    summary();
    $finish;
  end

endmodule